// File: doc/BRIEF.md
# Two-Phase Signature Self-Test Controller

This block sequences a built-in self-test for one datapath channel. While a test phase runs, it drives the channel's sample input with a pseudo-noise word from a 16-bit maximal-length shift register instead of the normal sample stream. It folds every valid 16-bit result coming back from the datapath into a 16-bit multiple-input signature register. When not testing, the normal sample passes through to the stimulus output one cycle late.

Software runs the test in two separately started phases. Before each phase it pulses the channel reset, and then it writes the run bit. Hardware clears the run bit after a fixed number of valid results. The stimulus generator and the signature register are seeded and cleared only when phase one starts, so phase two continues both sequences. When phase two completes, the computed signature is compared with an expected value that software loaded earlier. The outcome appears as bit 12 of the status register and on a dedicated output pin.

Top module: `bist_seq_ctrl`

## Requirements
- R1: After synchronous reset, `bist_active` and `sig_match` are 0, and reads of the control (address 0), signature (address 1) and status (address 2) registers return 0. A read returns the register contents as they stood at the clock edge that samples `reg_addr`, one cycle later on `reg_rdata`.
- R2: While no phase runs, `stim_out` equals the `norm_sample` value from the previous clock edge.
- R3: A write to address 0 with bit 0 set starts a phase only if `chan_rst` was pulsed while idle at an earlier edge and no phase has started since then. Otherwise the write is ignored.
- R4: While a phase runs, `stim_out` is the pseudo-noise word. It is 0xACE1 at the start of phase one. On each valid result it steps from s to {s[14:0], s[15]^s[13]^s[12]^s[10]}, and it holds while `dp_valid` is low.
- R5: The signature is cleared when phase one starts. On each valid result during a phase it becomes {m[14:0], m[15]^m[13]^m[12]^m[10]} XOR `dp_result`. Software reads it in bits 31:16 of address 1.
- R6: A phase ends, and control bit 0 (`bist_active`) clears, at the edge that takes exactly SAMPLES valid results. `dp_valid` while idle changes neither the signature nor the stimulus.
- R7: Phase two neither reseeds the stimulus nor clears the signature, so after both phases the signature covers 2*SAMPLES results in one sequence.
- R8: One cycle after phase two ends, status bit 12 and `sig_match` take the result of comparing the computed signature with the expected value. Phase one's end never sets them.
- R9: Starting phase one clears status bit 12 and `sig_match`.
- R10: Writes to address 1 store bits 15:0 as the expected signature, which reads back in bits 15:0. Written bits 31:16 are ignored.
- R11: Writes to address 0 while a phase runs, whether of 0 or 1, neither stop nor restart it.
- R12: An expected-signature write in the same cycle as the last valid result of phase two is the value used by the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_rst | input | 1 | Channel reset pulse that arms the next phase start |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 signature, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| norm_sample | input | DATA_W | Normal channel sample |
| stim_out | output | DATA_W | Sample driven into the datapath |
| dp_result | input | DATA_W | Datapath output word |
| dp_valid | input | 1 | Datapath output valid strobe |
| bist_active | output | 1 | A test phase is running |
| sig_match | output | 1 | Signature comparison result |

## Verification
The last valid result of phase two and a software write of the expected signature can occur in the same clock cycle. The comparison must then use the freshly written value. The bench provokes this case by waiting until its model counts the final driven sample and driving the write on that same edge, with a deliberately wrong value loaded beforehand. A correct design reports a match, and one that compares against the stale value does not. The bench also sweeps three valid-strobe patterns and checks the stimulus word against its own model on every active cycle. It also issues control writes in the middle of a phase.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;
  localparam int REG_W = 32;
  localparam int MATCH_BIT = 12;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_SIG  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [15:0] DEF_TAPS = 16'hB400;
  localparam logic [15:0] DEF_SEED = 16'hACE1;
endpackage

// File: rtl/bist_pn_source.sv
module bist_pn_source #(
  parameter int W = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] word
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst || load) state_q <= SEED;
    else if (step)   state_q <= {state_q[W-2:0], ^(state_q & TAPS)};
  end

  assign word = state_q;

  // maximal-length sequence never reaches the all-zero word
  assert_pn_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);
endmodule

// File: rtl/bist_sig_compactor.sv
module bist_sig_compactor #(
  parameter int W = 16,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         absorb,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig
);
  logic [W-1:0] sig_q;

  always_ff @(posedge clk) begin
    if (rst || clr)  sig_q <= '0;
    else if (absorb) sig_q <= {sig_q[W-2:0], ^(sig_q & TAPS)} ^ din;
  end

  assign sig = sig_q;

  assert_sig_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!absorb && !clr) |=> $stable(sig_q));
endmodule

// File: rtl/bist_phase_seq.sv
module bist_phase_seq #(
  parameter int SAMPLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic chan_rst,
  input  logic smp_valid,
  output logic busy,
  output logic seed_load,
  output logic absorb,
  output logic cmp_pend
);
  localparam int CW = (SAMPLES > 2) ? $clog2(SAMPLES) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(SAMPLES - 1);

  logic          busy_q, armed_q, p2_next_q, cur_second_q, cmp_q;
  logic [CW-1:0] cnt_q;
  logic          start_ok, last_smp;

  assign start_ok  = start_req && armed_q && !busy_q;
  assign seed_load = start_ok && !p2_next_q;
  assign absorb    = busy_q && smp_valid;
  assign last_smp  = absorb && (cnt_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q       <= 1'b0;
      armed_q      <= 1'b0;
      p2_next_q    <= 1'b0;
      cur_second_q <= 1'b0;
      cmp_q        <= 1'b0;
      cnt_q        <= '0;
    end else begin
      cmp_q <= 1'b0;
      if (start_ok) begin
        busy_q       <= 1'b1;
        armed_q      <= 1'b0;
        cur_second_q <= p2_next_q;
        cnt_q        <= '0;
      end else if (chan_rst && !busy_q) begin
        armed_q <= 1'b1;
      end
      if (last_smp) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
        if (cur_second_q) begin
          p2_next_q <= 1'b0;
          cmp_q     <= 1'b1;
        end else begin
          p2_next_q <= 1'b1;
        end
      end else if (absorb) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy     = busy_q;
  assign cmp_pend = cmp_q;

  assert_start_armed_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(armed_q) && $past(start_req));
  assert_end_on_valid_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(smp_valid));
  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST_IDX);
  assert_cmp_after_second_R8: assert property (@(posedge clk) disable iff (rst)
    cmp_q |-> $fell(busy_q) && $past(cur_second_q));
endmodule

// File: rtl/bist_seq_ctrl.sv
module bist_seq_ctrl
  import bist_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SAMPLES = 1024,
  parameter logic [DATA_W-1:0] TAPS = DEF_TAPS,
  parameter logic [DATA_W-1:0] SEED = DEF_SEED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chan_rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [DATA_W-1:0] norm_sample,
  output logic [DATA_W-1:0] stim_out,
  input  logic [DATA_W-1:0] dp_result,
  input  logic              dp_valid,
  output logic              bist_active,
  output logic              sig_match
);
  logic              start_req, busy, seed_load, absorb, cmp_pend;
  logic [DATA_W-1:0] pn_word, sig_word, user_sig_q, norm_q;
  logic              match_q;
  logic [REG_W-1:0]  rdata_q;

  assign start_req = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[0];

  bist_phase_seq #(.SAMPLES(SAMPLES)) u_seq (
    .clk(clk), .rst(rst), .start_req(start_req), .chan_rst(chan_rst),
    .smp_valid(dp_valid), .busy(busy), .seed_load(seed_load),
    .absorb(absorb), .cmp_pend(cmp_pend));

  bist_pn_source #(.W(DATA_W), .TAPS(TAPS), .SEED(SEED)) u_pn (
    .clk(clk), .rst(rst), .load(seed_load), .step(absorb), .word(pn_word));

  bist_sig_compactor #(.W(DATA_W), .TAPS(TAPS)) u_sig (
    .clk(clk), .rst(rst), .clr(seed_load), .absorb(absorb),
    .din(dp_result), .sig(sig_word));

  always_ff @(posedge clk) begin
    if (rst) begin
      norm_q     <= '0;
      user_sig_q <= '0;
      match_q    <= 1'b0;
      rdata_q    <= '0;
    end else begin
      norm_q <= norm_sample;
      if (reg_wr && (reg_addr == ADDR_SIG)) user_sig_q <= reg_wdata[DATA_W-1:0];
      if (seed_load)     match_q <= 1'b0;
      else if (cmp_pend) match_q <= (sig_word == user_sig_q);
      case (reg_addr)
        ADDR_CTRL: rdata_q <= REG_W'(busy);
        ADDR_SIG:  rdata_q <= REG_W'({sig_word, user_sig_q});
        ADDR_STAT: rdata_q <= REG_W'(match_q) << MATCH_BIT;
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign stim_out    = busy ? pn_word : norm_q;
  assign bist_active = busy;
  assign sig_match   = match_q;
  assign reg_rdata   = rdata_q;

  assert_match_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(match_q) |-> $past(cmp_pend));
  assert_match_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $past(seed_load) |-> !match_q);
  assert_stim_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(dp_valid)) |-> $stable(stim_out));
  assert_stop_needs_samples_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && !dp_valid) |=> busy);
endmodule

// File: tb/bist_seq_ctrl_test.sv
module bist_seq_ctrl_test;
  localparam int N = 32;
  localparam logic [15:0] TAPS = 16'hB400;
  localparam logic [15:0] SEED = 16'hACE1;

  logic clk = 0, rst = 1, chan_rst = 0, reg_wr = 0, dp_valid = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [15:0] norm_sample = 0, stim_out, dp_result;
  logic bist_active, sig_match;
  int tests = 0, fails = 0, vmode = 0, cyc = 0, mon_cnt = 0;
  logic mon_en = 0;
  logic [15:0] mon_s = SEED;

  always #5 clk = ~clk;

  bist_seq_ctrl #(.SAMPLES(N)) uut (
    .clk(clk), .rst(rst), .chan_rst(chan_rst), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .norm_sample(norm_sample), .stim_out(stim_out), .dp_result(dp_result),
    .dp_valid(dp_valid), .bist_active(bist_active), .sig_match(sig_match));

  function automatic logic [15:0] dp_model(input logic [15:0] s);
    return {s[7:0], s[15:8]} ^ 16'h3C5A;
  endfunction
  function automatic logic [15:0] step16(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
  function automatic logic [15:0] sig_after(input int k);
    logic [15:0] s = SEED, m = 0;
    for (int i = 0; i < k; i++) begin
      m = step16(m) ^ dp_model(s);
      s = step16(s);
    end
    return m;
  endfunction

  assign dp_result = dp_model(stim_out);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // valid-strobe driver with stimulus model (R4 R7)
  initial forever begin
    logic v;
    @(negedge clk);
    cyc++;
    if (mon_en && bist_active) check("R4 R7 stim word", 32'(stim_out), 32'(mon_s));
    case (vmode)
      0: v = 1'b1;
      1: v = (cyc % 3) == 0;
      default: v = ((cyc >> 2) ^ cyc) & 1;
    endcase
    dp_valid = v;
    if (bist_active && v) begin
      mon_s = step16(mon_s);
      mon_cnt++;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask
  task automatic pulse_crst;
    @(negedge clk); chan_rst = 1;
    @(negedge clk); chan_rst = 0;
  endtask
  task automatic start(input bit first);
    pulse_crst();
    @(negedge clk);
    if (first) mon_s = SEED;
    mon_cnt = 0;
    reg_wr = 1; reg_addr = 0; reg_wdata = 1;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic wait_done(input string tag);
    int k = 0;
    while (bist_active && k < 5000) begin @(negedge clk); k++; end
    check({tag, " phase completes"}, 32'(bist_active), 0);
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    check("R1 active", 32'(bist_active), 0);
    check("R1 match", 32'(sig_match), 0);
    rd(0, r); check("R1 ctrl", r, 0);
    rd(1, r); check("R1 sig", r, 0);
    rd(2, r); check("R1 status", r, 0);
    // R2
    for (int i = 0; i < 4; i++) begin
      logic [15:0] x = 16'(16'h1357 * (i + 3));
      @(negedge clk); norm_sample = x;
      @(negedge clk); check("R2 passthrough", 32'(stim_out), 32'(x));
    end
    // R10
    wr(1, 32'hFFFF_0000 | 32'(sig_after(N)));
    rd(1, r); check("R10 user sig readback", r, 32'(sig_after(N)));
    // R3: start without channel reset
    wr(0, 1); repeat (2) @(negedge clk);
    check("R3 unarmed start ignored", 32'(bist_active), 0);

    // Test A phase one, strobe every third cycle
    mon_en = 1; vmode = 1;
    start(1);
    check("R4 first word", 32'(stim_out), 32'(SEED));
    repeat (10) @(negedge clk);
    wr(0, 0);
    check("R11 write 0 while busy", 32'(bist_active), 1);
    wr(0, 1);
    check("R11 write 1 while busy", 32'(bist_active), 1);
    wait_done("R6");
    check("R6 sample count", 32'(mon_cnt), N);
    repeat (10) @(negedge clk);
    rd(1, r); check("R5 R6 signature after phase one", r, {sig_after(N), sig_after(N)});
    rd(2, r); check("R8 no match after phase one", r, 0);
    wr(0, 1); repeat (2) @(negedge clk);
    check("R3 phase two needs channel reset", 32'(bist_active), 0);
    // phase two, irregular strobe
    vmode = 2;
    start(0);
    wait_done("R7");
    repeat (2) @(negedge clk);
    rd(1, r); check("R7 signature after phase two", r[31:16], 32'(sig_after(2*N)));
    rd(2, r); check("R8 mismatch", r, 0);
    check("R8 mismatch pin", 32'(sig_match), 0);

    // Test B: full match, strobe every cycle
    vmode = 0;
    wr(1, 32'(sig_after(2*N)));
    start(1); wait_done("R6");
    rd(2, r); check("R8 no match after phase one B", r, 0);
    start(0); wait_done("R6");
    repeat (2) @(negedge clk);
    rd(2, r); check("R8 status bit 12", r, 32'h0000_1000);
    check("R8 match pin", 32'(sig_match), 1);

    // Test C: clear on phase one, write lands with last sample
    start(1);
    @(negedge clk);
    check("R9 match cleared", 32'(sig_match), 0);
    rd(2, r); check("R9 status cleared", r, 0);
    wait_done("R6");
    wr(1, 32'(~sig_after(2*N)));
    start(0);
    wait (mon_cnt == N);
    reg_wr = 1; reg_addr = 1; reg_wdata = 32'(sig_after(2*N));
    @(negedge clk); reg_wr = 0;
    wait_done("R12");
    repeat (2) @(negedge clk);
    check("R12 same-cycle expected value used", 32'(sig_match), 1);
    rd(1, r); check("R12 readback", r, {sig_after(2*N), sig_after(2*N)});

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R6 actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule